// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block turns word read requests from a valid/ready port into read cycles on an asynchronous parallel NOR-style flash bus. It drives the word address, an active-low chip enable and an active-low output enable, keeps the write enable inactive, and captures the flash data bus once the programmed number of wait cycles has passed. The result goes back with a one-cycle response strobe.

The controller keeps chip enable low between requests. It remembers which 4-word page the flash last presented. A read that falls in that page while chip enable has stayed low uses the short page access time. A read to another page, or the first read after chip enable was released, uses the full initial access time. Both times are parameters in clock cycles. The bus is released after a run of idle cycles or when a disable input is raised, and releasing it forgets the open page. The flash is in read-array mode after reset, so no command cycles are ever issued.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `fl_ce_n` and `fl_oe_n` are 1, `rsp_valid` is 0 and `req_ready` equals the inverse of `bus_disable`.
- R2: Word address bits [1:0] pick the word inside a page. Bits [ADDR_W-1:2] form the page number. A request is a page hit only if its page number equals the page of the previous accepted read and the chip enable has not been released since that read.
- R3: For a page miss, `rsp_valid` is high in the cycle after the T_FULL-th rising edge that follows the accept edge.
- R4: For a page hit, `rsp_valid` is high in the cycle after the T_PAGE-th rising edge that follows the accept edge.
- R5: After chip enable has been released, the next read uses the T_FULL latency even if it targets the page read last.
- R6: After a response edge, if IDLE_MAX rising edges pass with no accepted request and `bus_disable` low, then `fl_ce_n` and `fl_oe_n` go to 1 at the last of those edges. A request accepted on that same edge keeps the bus enabled and counts as a hit when its page matches.
- R7: While `bus_disable` is high, no request is accepted. The bus is released at the first edge with no access in flight. A read already in flight still completes with its normal latency.
- R8: `rsp_valid` is high for one cycle per accepted read. In that cycle `rsp_data` holds the value present on `fl_dq_in` at the edge where the wait ended, and chip enable is asserted.
- R9: `req_ready` is 0 from the accept edge until the response edge.
- R10: `fl_we_n` is always 1. `fl_ce_n` and `fl_oe_n` always have the same value.
- R11: From the edge after an accept, `fl_addr` holds the accepted address until the next accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| bus_disable | input | 1 | Block new requests and release the flash bus |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | DATA_W | Read data |
| fl_addr | output | ADDR_W | Flash word address |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, held high |
| fl_dq_in | input | DATA_W | Flash data bus |

## Verification
The response is due exactly T_PAGE or T_FULL edges after the accept edge, depending on the hit decision. The bench model works out that decision from the page number and from the release history of the bus, then queues the due edge together with the expected word. A release is due at the IDLE_MAX-th idle edge, or at the first non-busy edge with `bus_disable` high. Address capture and the drop of `req_ready` are due at the accept edge itself. The model updates at each rising edge, and every output is compared at the following falling edge, once all registers along the path have settled. This way each result is checked in the one cycle it belongs to, and a response one cycle early or late is reported.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {
    BUS_OFF  = 2'd0,
    BUS_OPEN = 2'd1,
    BUS_READ = 2'd2
  } bus_st_t;
endpackage

// File: rtl/pflash_page_track.sv
module pflash_page_track #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [TAG_W-1:0] page_in,
  output logic             hit
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (load) begin
      tag_q <= page_in;
    end
  end

  assign hit = valid_q && (tag_q == page_in);
endmodule

// File: rtl/pflash_wait_timer.sv
module pflash_wait_timer #(
  parameter int T_FULL = 6,
  parameter int T_PAGE = 2,
  parameter int CNT_W  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic use_page,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= use_page ? CNT_W'(T_PAGE) : CNT_W'(T_FULL);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pflash_idle_timer.sv
module pflash_idle_timer #(
  parameter int IDLE_MAX = 16,
  parameter int IDLE_W   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expire
);
  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = tick && (cnt_q == IDLE_W'(IDLE_MAX - 1));
endmodule

// File: rtl/pflash_rd_ctrl.sv
module pflash_rd_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int PAGE_W   = 2,
  parameter int T_FULL   = 6,
  parameter int T_PAGE   = 2,
  parameter int IDLE_MAX = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              bus_disable,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  input  logic [DATA_W-1:0] fl_dq_in
);
  localparam int TAG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(T_FULL + 1);
  localparam int IDLE_W = $clog2(IDLE_MAX + 1);

  bus_st_t st_q, st_d;
  logic    busy, accept, hit, tmr_done, done;
  logic    idle_tick, idle_clr, idle_exp, release_bus;

  logic              ce_n_q, oe_n_q, rsp_valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign busy      = (st_q == BUS_READ);
  assign req_ready = !busy && !bus_disable;
  assign accept    = req_valid && req_ready;

  pflash_page_track #(.TAG_W(TAG_W)) u_page (
    .clk     (clk),
    .rst     (rst),
    .clr     (release_bus),
    .load    (accept),
    .page_in (req_addr[ADDR_W-1:PAGE_W]),
    .hit     (hit)
  );

  pflash_wait_timer #(.T_FULL(T_FULL), .T_PAGE(T_PAGE), .CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .use_page (hit),
    .done     (tmr_done)
  );

  assign idle_tick = (st_q == BUS_OPEN) && !accept && !bus_disable;
  assign idle_clr  = (st_q != BUS_OPEN);

  pflash_idle_timer #(.IDLE_MAX(IDLE_MAX), .IDLE_W(IDLE_W)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .clear  (idle_clr),
    .tick   (idle_tick),
    .expire (idle_exp)
  );

  assign done        = busy && tmr_done;
  assign release_bus = (st_q == BUS_OPEN) && !accept && (bus_disable || idle_exp);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BUS_OFF:  if (accept) st_d = BUS_READ;
      BUS_OPEN: begin
        if (accept)           st_d = BUS_READ;
        else if (release_bus) st_d = BUS_OFF;
      end
      BUS_READ: if (done) st_d = BUS_OPEN;
      default:  st_d = BUS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= BUS_OFF;
      ce_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      ce_n_q      <= (st_d == BUS_OFF);
      oe_n_q      <= (st_d == BUS_OFF);
      rsp_valid_q <= done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      rsp_data_q <= '0;
    end else begin
      if (accept) addr_q     <= req_addr;
      if (done)   rsp_data_q <= fl_dq_in;
    end
  end

  assign fl_addr   = addr_q;
  assign fl_ce_n   = ce_n_q;
  assign fl_oe_n   = oe_n_q;
  assign fl_we_n   = 1'b1;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/pflash_rd_chk.sv
module pflash_rd_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              fl_ce_n,
  input logic              fl_oe_n
);
  logic accepted;
  assign accepted = req_valid && req_ready;

  // R9: ready drops right after an accept
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    accepted |=> !req_ready);

  // R11: the accepted address is on the bus in the next cycle
  a_r11_addr_capture: assert property (@(posedge clk) disable iff (rst)
    accepted |=> (fl_addr == $past(req_addr)));

  // R8: the response strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8: data is returned only while chip enable is asserted
  a_r8_rsp_with_ce: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !fl_ce_n);

  // R10: chip enable and output enable move together
  a_r10_ce_oe_pair: assert property (@(posedge clk) disable iff (rst)
    fl_ce_n == fl_oe_n);
endmodule

bind pflash_rd_ctrl pflash_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .fl_addr   (fl_addr),
  .fl_ce_n   (fl_ce_n),
  .fl_oe_n   (fl_oe_n)
);

// File: tb/pflash_rd_ctrl_bench.sv
module pflash_rd_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TF = 5;
  localparam int TP = 2;
  localparam int IM = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic bus_disable = 1'b0;
  logic req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n;
  logic [DW-1:0] rsp_data, fl_dq_in;
  logic [AW-1:0] fl_addr;

  int errors = 0;
  int checks = 0;
  logic running = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
    return DW'((a * 16'h9E37) ^ 16'h5A5A);
  endfunction

  // flash: data only while both enables are low
  assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? fdata(fl_addr) : 16'hFFFF;

  pflash_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(2), .T_FULL(TF),
                   .T_PAGE(TP), .IDLE_MAX(IM)) u_pflash_rd_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .bus_disable(bus_disable), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .fl_addr(fl_addr), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_dq_in(fl_dq_in));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int    cyc = 0;
  bit    m_ce = 0, m_valid = 0, m_busy = 0, m_rsp = 0;
  int    m_tag = -1, m_idle = 0, m_addr = 0;
  int    q_due[$];
  string q_tag[$];
  string m_rtag = "R8", m_cetag = "R1";
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ce = 0; m_valid = 0; m_busy = 0; m_rsp = 0; m_idle = 0;
      q_due.delete(); q_tag.delete(); cyc = 0;
    end else begin
      bit pre_ready;
      cyc++;
      pre_ready = !m_busy && !bus_disable;
      m_rsp = 0;
      m_rtag = "R8";
      if (m_busy && q_due.size() > 0 && cyc == q_due[0]) begin
        m_busy = 0; m_rsp = 1; m_data = fdata(AW'(m_addr)); m_idle = 0;
        m_rtag = q_tag[0];
        void'(q_due.pop_front()); void'(q_tag.pop_front());
      end else if (pre_ready && req_valid) begin
        bit hit;
        hit = m_ce && m_valid && (int'(req_addr >> 2) == m_tag);
        q_due.push_back(cyc + (hit ? TP : TF));
        q_tag.push_back(hit ? "R4" : (m_tag == int'(req_addr >> 2) ? "R5" : "R3"));
        m_busy = 1; m_ce = 1; m_valid = 1; m_tag = int'(req_addr >> 2);
        m_addr = int'(req_addr); m_cetag = "R11";
      end else if (!m_busy && m_ce) begin
        if (bus_disable) begin
          m_ce = 0; m_valid = 0; m_cetag = "R7";
        end else begin
          m_idle++;
          if (m_idle == IM) begin m_ce = 0; m_valid = 0; m_cetag = "R6"; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(m_rtag, rsp_valid, m_rsp);
      if (m_rsp) chk("R8", rsp_data, m_data);
      chk("R9", req_ready, !m_busy && !bus_disable);
      chk(m_cetag, fl_ce_n, !m_ce);
      chk("R10", fl_oe_n, !m_ce);
      chk("R10", fl_we_n, 1);
      if (m_ce) chk("R11", fl_addr, m_addr);
    end
  end

  task automatic rd(input logic [AW-1:0] a, input int gap);
    bit ok;
    @(negedge clk); #2;
    req_valid = 1'b1; req_addr = a;
    forever begin
      ok = req_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk); #2;
    end
    @(negedge clk); #2;
    req_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", fl_ce_n, 1); chk("R1", fl_oe_n, 1);
    chk("R1", rsp_valid, 0); chk("R1", req_ready, 1);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R1", fl_ce_n, 1); chk("R1", rsp_valid, 0);
    running = 1'b1;
    // R3 first read, R4 hits in the same page, R2 page boundaries
    rd(16'h0010, 0); wait_done();
    rd(16'h0011, 0); wait_done();
    rd(16'h0013, 0); wait_done();
    rd(16'h0012, 0); wait_done();
    rd(16'h0014, 0); wait_done();
    rd(16'h1014, 0); wait_done();
    rd(16'h0017, 0); wait_done();
    // R6 idle release, then R5 same page pays full time
    repeat (IM + 3) @(negedge clk);
    rd(16'h0016, 0); wait_done();
    // R7 disable while in flight and while idle
    rd(16'h0015, 0);
    bus_disable = 1'b1;
    repeat (TF + 3) @(negedge clk);
    #2 bus_disable = 1'b0;
    rd(16'h0015, 0); wait_done();
    // R6 corner: request exactly at the expiry edge and around it
    for (int g = IM - 2; g <= IM + 1; g++) begin
      rd(16'h0020, 0); wait_done();
      repeat (g) @(negedge clk);
      rd(16'h0021, 0); wait_done();
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 == 0) ? AW'($urandom) : AW'({fl_addr[AW-1:2], 2'(($urandom))});
      if ($urandom % 16 == 0) begin
        @(negedge clk); #2 bus_disable = 1'b1;
        repeat ($urandom % 4) @(negedge clk);
        #2 bus_disable = 1'b0;
      end
      rd(a, $urandom % (IM + 2));
    end
    repeat (TF + IM + 4) @(negedge clk);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule